// File: doc/BRIEF.md
# ATA DMA Channel Control Unit

This block is the register front end for one channel of a packet-driven ATA DMA engine. A host writes and reads a small set of registers over a simple memory-mapped bus. The registers select the PIO timing mode, hold the command-block count, the next command-block address and the FIFO thresholds, and carry one-shot commands that start packet execution or return the engine to idle. The engine reports events on a pulse input. The unit latches these events into a status register and raises a level interrupt unless the interrupt is masked.

A single control write carries several things at once. It sets the timing mode and the interrupt mask, fires the start or reset command, and chooses between packet mode and direct register mode. Reading the status register returns the latched events and clears them in the same access. Any nonzero status is the interrupt cause.

Bus protocol:
- A request is one cycle with `req_i` high.
- A write takes effect at that clock edge.
- Read data appears on `rdata_o` after the same edge and holds until the next read.

Top module: `chan_dma_ctl`

## Requirements
- R1: After reset, every output is 0 and a read of any register returns 0.
- R2: A write to offset 0x00 stores the interrupt mask from bit 8 and the PIO timing mode from bits 1:0. The mode is driven on `pio_mode_o`. A read of 0x00 returns only those bits, and every other bit reads 0.
- R3: A write to 0x00 with bit 7 set and bit 5 clear makes `go_o` high for exactly the one cycle after the write. The same write sets `pkt_mode_o` from that cycle on. Bit 7 always reads back as 0.
- R4: A write to 0x00 with bit 5 set makes `eng_rst_o` high for exactly the one cycle after the write, and it clears `pkt_mode_o` and the latched status. In that write, bit 7 produces no `go_o` pulse.
- R5: A write to 0x00 with bit 7 clear drives `pkt_mode_o` to 0, which is direct register mode.
- R6: Each set bit of `evt_i` is latched into the 8-bit status register. Bits accumulate until they are cleared. Bit 0 means host bus or parity error, bit 4 means unexpected device interrupt, and bit 6 means packet sequence fault.
- R7: A read of offset 0x02 returns the latched status and clears it. An event present in the same cycle as the read stays latched.
- R8: `irq_o` is high exactly while the status is nonzero and the mask bit is 0. It falls in the cycle after a clearing read, provided no new event arrives.
- R9: Offset 0x04 holds a 16-bit command-block count, 0x14 a 16-bit input FIFO threshold and 0x16 a 16-bit output FIFO threshold. Each is readable and drives its output.
- R10: Offset 0x0C holds the 32-bit next command-block address. Written bits 2:0 are ignored and read as 0.
- R11: Writes to any other offset change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid after the read edge |
| evt_i | input | 8 | Event pulses from the packet engine |
| go_o | output | 1 | Start pulse to the packet engine |
| eng_rst_o | output | 1 | Engine reset pulse |
| pkt_mode_o | output | 1 | 1 = packet mode, 0 = direct register mode |
| pio_mode_o | output | 2 | PIO timing mode select |
| cpb_count_o | output | 16 | Command-block count |
| next_addr_o | output | 32 | Next command-block address, 8-byte aligned |
| fifo_in_thr_o | output | 16 | Input FIFO threshold |
| fifo_out_thr_o | output | 16 | Output FIFO threshold |
| irq_o | output | 1 | Channel interrupt, level |

## Verification
A wrong internal state shows at the ports within one or two cycles:
- A stuck or missing command flop shows as a `go_o` or `eng_rst_o` pulse that is missing, doubled or unsuppressed in the cycle after the control write.
- A wrong mode flag shows on `pkt_mode_o` in that same cycle.
- A status latch that loses an event, fails to clear, or clears an event that arrives with the read shows on `irq_o` one cycle later, and on the value of the following status read.
- A corrupted configuration register shows at once on its output, and on the next read of it.

// File: rtl/chan_dma_pkg.sv
package chan_dma_pkg;
  localparam int unsigned N_REGS = 6;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_CNT   = 3'd2,
    REG_NADDR = 3'd3,
    REG_FIN   = 3'd4,
    REG_FOUT  = 3'd5
  } reg_idx_e;

  localparam logic [4:0] OFS_CTRL  = 5'h00;
  localparam logic [4:0] OFS_STAT  = 5'h02;
  localparam logic [4:0] OFS_CNT   = 5'h04;
  localparam logic [4:0] OFS_NADDR = 5'h0C;
  localparam logic [4:0] OFS_FIN   = 5'h14;
  localparam logic [4:0] OFS_FOUT  = 5'h16;

  localparam int unsigned CTL_GO_BIT   = 7;
  localparam int unsigned CTL_RST_BIT  = 5;
  localparam int unsigned CTL_MASK_BIT = 8;
  localparam int unsigned CTL_RB_W     = 16;

  function automatic logic [4:0] reg_ofs(input int unsigned idx);
    case (idx)
      0:       return OFS_CTRL;
      1:       return OFS_STAT;
      2:       return OFS_CNT;
      3:       return OFS_NADDR;
      4:       return OFS_FIN;
      default: return OFS_FOUT;
    endcase
  endfunction
endpackage

// File: rtl/chan_dma_dec.sv
module chan_dma_dec #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic [chan_dma_pkg::N_REGS-1:0]   sel_o
);
  for (genvar i = 0; i < chan_dma_pkg::N_REGS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(chan_dma_pkg::reg_ofs(i)));
  end
endmodule

// File: rtl/chan_dma_ctrl.sv
module chan_dma_ctrl #(
  parameter int unsigned PIO_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             go_bit_i,
  input  logic             rst_bit_i,
  input  logic             mask_bit_i,
  input  logic [PIO_W-1:0] pio_i,
  output logic             mask_o,
  output logic [PIO_W-1:0] pio_o,
  output logic             go_o,
  output logic             eng_rst_o,
  output logic             pkt_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= 1'b0;
      pio_o      <= '0;
      go_o       <= 1'b0;
      eng_rst_o  <= 1'b0;
      pkt_mode_o <= 1'b0;
    end else begin
      // command bits are one-shot; reset wins over go
      go_o      <= wr_i & go_bit_i & ~rst_bit_i;
      eng_rst_o <= wr_i & rst_bit_i;
      if (wr_i) begin
        mask_o     <= mask_bit_i;
        pio_o      <= pio_i;
        pkt_mode_o <= go_bit_i & ~rst_bit_i;
      end
    end
  end
endmodule

// File: rtl/chan_dma_stat.sv
module chan_dma_stat #(
  parameter int unsigned ST_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] evt_i,
  input  logic            rd_clr_i,
  input  logic            wipe_i,
  input  logic            mask_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_o <= '0;
    else if (wipe_i)   status_o <= '0;
    else if (rd_clr_i) status_o <= evt_i;           // same-cycle event survives
    else               status_o <= status_o | evt_i;
  end

  assign irq_o = (|status_o) & ~mask_i;
endmodule

// File: rtl/chan_dma_cfg.sv
module chan_dma_cfg #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i & KEEP;
  end
endmodule

// File: rtl/chan_dma_ctl.sv
module chan_dma_ctl
  import chan_dma_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ST_W    = 8,
  parameter int unsigned PIO_W   = 2,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned THR_W   = 16,
  parameter int unsigned PTR_W   = 32,
  parameter int unsigned ALIGN_B = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ST_W-1:0]   evt_i,
  output logic              go_o,
  output logic              eng_rst_o,
  output logic              pkt_mode_o,
  output logic [PIO_W-1:0]  pio_mode_o,
  output logic [CNT_W-1:0]  cpb_count_o,
  output logic [PTR_W-1:0]  next_addr_o,
  output logic [THR_W-1:0]  fifo_in_thr_o,
  output logic [THR_W-1:0]  fifo_out_thr_o,
  output logic              irq_o
);
  localparam logic [PTR_W-1:0] PTR_KEEP = {{(PTR_W-ALIGN_B){1'b1}}, {ALIGN_B{1'b0}}};

  logic [N_REGS-1:0] sel;
  logic [N_REGS-1:0] wr;
  logic              rd;
  logic              mask;
  logic [ST_W-1:0]   status;
  logic [CTL_RB_W-1:0] ctrl_rb;
  logic [DATA_W-1:0] rd_mux;

  chan_dma_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr = {N_REGS{req_i & we_i}} & sel;
  assign rd = req_i & ~we_i;

  chan_dma_ctrl #(.PIO_W(PIO_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr[REG_CTRL]),
    .go_bit_i   (wdata_i[CTL_GO_BIT]),
    .rst_bit_i  (wdata_i[CTL_RST_BIT]),
    .mask_bit_i (wdata_i[CTL_MASK_BIT]),
    .pio_i      (wdata_i[PIO_W-1:0]),
    .mask_o     (mask),
    .pio_o      (pio_mode_o),
    .go_o       (go_o),
    .eng_rst_o  (eng_rst_o),
    .pkt_mode_o (pkt_mode_o)
  );

  chan_dma_stat #(.ST_W(ST_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .rd_clr_i (rd & sel[REG_STAT]),
    .wipe_i   (wr[REG_CTRL] & wdata_i[CTL_RST_BIT]),
    .mask_i   (mask),
    .status_o (status),
    .irq_o    (irq_o)
  );

  chan_dma_cfg #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr[REG_CNT]),
    .d_i (wdata_i[CNT_W-1:0]), .q_o (cpb_count_o)
  );

  chan_dma_cfg #(.W(PTR_W), .KEEP(PTR_KEEP)) u_naddr (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr[REG_NADDR]),
    .d_i (wdata_i[PTR_W-1:0]), .q_o (next_addr_o)
  );

  chan_dma_cfg #(.W(THR_W)) u_fin (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr[REG_FIN]),
    .d_i (wdata_i[THR_W-1:0]), .q_o (fifo_in_thr_o)
  );

  chan_dma_cfg #(.W(THR_W)) u_fout (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr[REG_FOUT]),
    .d_i (wdata_i[THR_W-1:0]), .q_o (fifo_out_thr_o)
  );

  always_comb begin
    ctrl_rb               = '0;
    ctrl_rb[CTL_MASK_BIT] = mask;
    ctrl_rb[PIO_W-1:0]    = pio_mode_o;
  end

  always_comb begin
    rd_mux = '0;
    if (sel[REG_CTRL])  rd_mux = DATA_W'(ctrl_rb);
    if (sel[REG_STAT])  rd_mux = DATA_W'(status);
    if (sel[REG_CNT])   rd_mux = DATA_W'(cpb_count_o);
    if (sel[REG_NADDR]) rd_mux = DATA_W'(next_addr_o);
    if (sel[REG_FIN])   rd_mux = DATA_W'(fifo_in_thr_o);
    if (sel[REG_FOUT])  rd_mux = DATA_W'(fifo_out_thr_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/chan_dma_ctl_chk.sv
module chan_dma_ctl_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ST_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ST_W-1:0]   evt_i,
  input logic              go_o,
  input logic              eng_rst_o,
  input logic              pkt_mode_o,
  input logic              irq_o
);
  import chan_dma_pkg::*;

  logic past_ok;
  logic wr_ctrl, wr_go, wr_rst, wr_plain, rd_stat_quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign wr_ctrl       = req_i && we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_go         = wr_ctrl && wdata_i[CTL_GO_BIT] && !wdata_i[CTL_RST_BIT];
  assign wr_rst        = wr_ctrl && wdata_i[CTL_RST_BIT];
  assign wr_plain      = wr_ctrl && !wdata_i[CTL_GO_BIT];
  assign rd_stat_quiet = req_i && !we_i && (addr_i == ADDR_W'(OFS_STAT)) && (evt_i == '0);

  a_r3_go_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && go_o) |-> $past(wr_go));

  a_r3_go_enters_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_go)) |-> pkt_mode_o);

  a_r4_rst_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && eng_rst_o) |-> $past(wr_rst));

  a_r4_rst_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && eng_rst_o) |-> (!go_o && !pkt_mode_o));

  a_r5_reg_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_plain)) |-> !pkt_mode_o);

  a_r8_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(rd_stat_quiet)) |-> !irq_o);
endmodule

bind chan_dma_ctl chan_dma_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ST_W   (ST_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .evt_i      (evt_i),
  .go_o       (go_o),
  .eng_rst_o  (eng_rst_o),
  .pkt_mode_o (pkt_mode_o),
  .irq_o      (irq_o)
);

// File: tb/tb_chan_dma_ctl.sv
module tb_chan_dma_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  evt_i = '0;
  logic        go_o, eng_rst_o, pkt_mode_o, irq_o;
  logic [1:0]  pio_mode_o;
  logic [15:0] cpb_count_o, fifo_in_thr_o, fifo_out_thr_o;
  logic [31:0] next_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  chan_dma_ctl dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .we_i (we_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o), .evt_i (evt_i),
    .go_o (go_o), .eng_rst_o (eng_rst_o), .pkt_mode_o (pkt_mode_o),
    .pio_mode_o (pio_mode_o), .cpb_count_o (cpb_count_o),
    .next_addr_o (next_addr_o), .fifo_in_thr_o (fifo_in_thr_o),
    .fifo_out_thr_o (fifo_out_thr_o), .irq_o (irq_o)
  );

  localparam int NV = 8;
  localparam logic [4:0]  V_ADDR [NV] = '{5'h00, 5'h04, 5'h0C, 5'h14, 5'h16, 5'h08, 5'h10, 5'h00};
  localparam logic [31:0] V_WR   [NV] = '{32'h0000_01FF, 32'hABCD_1234, 32'hDEAD_BEEF, 32'h0000_0100,
                                          32'hFFFF_0155, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0002};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0000_0103, 32'h0000_1234, 32'hDEAD_BEE8, 32'h0000_0100,
                                          32'h0000_0155, 32'h0000_0000, 32'h0000_0000, 32'h0000_0002};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge; returns at the next negedge, after the acting edge
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [7:0] ev);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; evt_i = ev;
    @(negedge clk_i);
    req_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 outputs", {go_o, eng_rst_o, pkt_mode_o, irq_o, pio_mode_o}, '0);
    chk("R1 cfg", {cpb_count_o, fifo_in_thr_o} | next_addr_o | 32'(fifo_out_thr_o), '0);
    bus_rd(5'h00, '0);
    chk("R1 ctrl read", rdata_o, '0);
    bus_rd(5'h02, '0);
    chk("R1 status read", rdata_o, '0);

    // table: write then read back (R2, R9, R10, R11)
    for (int i = 0; i < NV; i++) begin
      bus_wr(V_ADDR[i], V_WR[i]);
      bus_rd(V_ADDR[i], '0);
      chk($sformatf("R2/R9/R10/R11 vec %0d", i), rdata_o, V_EXP[i]);
    end
    chk("R9 count out", 32'(cpb_count_o), 32'h1234);
    chk("R10 addr out", next_addr_o, 32'hDEAD_BEE8);
    chk("R9 fifo in out", 32'(fifo_in_thr_o), 32'h0100);
    chk("R9 fifo out out", 32'(fifo_out_thr_o), 32'h0155);
    chk("R2 pio out", 32'(pio_mode_o), 32'd2);
    chk("R11 unmapped writes no effect", 32'(irq_o), 0);

    // R3 go pulse
    bus_wr(5'h00, 32'h0000_0083);
    chk("R3 go high", {go_o, pkt_mode_o, eng_rst_o}, 3'b110);
    @(negedge clk_i);
    chk("R3 go one cycle", {go_o, pkt_mode_o}, 2'b01);
    chk("R2 pio mode 3", 32'(pio_mode_o), 32'd3);
    bus_rd(5'h00, '0);
    chk("R3 go reads 0", rdata_o, 32'h0000_0003);

    // R5 plain write leaves packet mode
    bus_wr(5'h00, 32'h0000_0003);
    chk("R5 reg mode", {go_o, pkt_mode_o}, 2'b00);

    // R6/R8 latch and interrupt
    pulse_evt(8'h11);
    chk("R8 irq raised", 32'(irq_o), 1);
    pulse_evt(8'h40);
    bus_rd(5'h02, '0);
    chk("R6 accumulate", rdata_o, 32'h51);
    chk("R8 irq drop", 32'(irq_o), 0);

    // R7 same-cycle event survives the clearing read
    pulse_evt(8'h10);
    bus_rd(5'h02, 8'h01);
    chk("R7 read value", rdata_o, 32'h10);
    chk("R7 irq kept", 32'(irq_o), 1);
    bus_rd(5'h02, '0);
    chk("R7 survivor", rdata_o, 32'h01);
    bus_rd(5'h02, '0);
    chk("R7 cleared", rdata_o, 32'h00);

    // R8 mask
    bus_wr(5'h00, 32'h0000_0103);
    pulse_evt(8'h04);
    chk("R8 masked", 32'(irq_o), 0);
    bus_wr(5'h00, 32'h0000_0003);
    chk("R8 unmasked", 32'(irq_o), 1);

    // R4 reset command with go set: reset wins, status wiped
    bus_wr(5'h00, 32'h0000_0083);
    @(negedge clk_i);
    bus_wr(5'h00, 32'h0000_00A3);
    chk("R4 rst pulse", {eng_rst_o, go_o, pkt_mode_o, irq_o}, 4'b1000);
    @(negedge clk_i);
    chk("R4 rst one cycle", 32'(eng_rst_o), 0);
    bus_rd(5'h02, '0);
    chk("R4 status wiped", rdata_o, 32'h0);
    bus_rd(5'h00, '0);
    chk("R4 ctrl readback", rdata_o, 32'h0000_0003);

    summary();
    $finish;
  end
endmodule